// File: doc/BRIEF.md
# Codec-Clocked Serial Audio Frame Port

This block is the host side of a serial audio link in which the codec drives both the bit clock and the frame sync. The port never generates either signal. It brings both in, together with the codec's serial data, and samples them with the system clock. Transmit and receive share the single incoming clock and sync, so the two directions stay phase-aligned. Received bits are collected into a left word, a right word and a status word. Words written by the host are shifted out on the serial data line.

Two frame shapes are supported:

- **Long frame (64 bit periods):** a 16-bit left element, a 16-bit right element, then a 32-bit status slot.
- **Short frame (32 bit periods):** only the two elements. The codec then stops its clock for the remaining half of the sample period.

A frame opens with an active-high sync pulse one bit period wide. The first data bit follows that pulse by one bit period. Each element goes most-significant bit first. Audio narrower than 16 bits sits left-justified in its element, with zeros after its last bit. A mono setting moves only the left element.

The host side is word-parallel, with valid/ready handshakes in both directions. Sticky flags report three faults: a sync pulse arriving mid-frame, a missing transmit word, and an unread receive word.

The frame controller is a state machine with two states:

- `FP_IDLE` waits for a sampled sync.
  - *idle-to-shift* is taken on a bit-clock fall with sync high.
- `FP_SHIFT` takes one bit per falling edge.
  - *shift-restart* is taken on a sync while in `FP_SHIFT`. It is legal on the last bit of a frame and an error on any earlier bit.
  - *shift-to-idle* is taken after the last bit when no sync is present.

Top module: `aud_frame_port`

## Requirements
- R1: After reset: `sdata_out` is 0, `rx_valid` is 0, `tx_ready` is 1, and all three error flags are 0.
- R2: A frame starts on the bit-clock falling edge at which `fsync_in` is sampled high. Data bit 0 is sampled on the next falling edge (one-bit delay). `sdata_in` is sampled on falling edges, and `sdata_out` changes only after rising edges.
- R3: Within a frame, the left element comes first, then the right. Each element is 16 bits, MSB first, so the first data bit lands in bit 15 of `rx_left`.
- R4: With `cfg_short`=0 a frame is 64 bits long:
  - frame bits 32..63 are returned in `rx_status`, with frame bit 32 in bit 31;
  - `sdata_out` is 0 during those bits;
  - a sync sampled together with bit 63 starts the next frame without any error.
- R5: With `cfg_short`=1 a frame ends after 32 bits. The port then waits, with the bit clock stopped, for the next sync. `rx_status` reads 0 and no error is raised.
- R6: With `cfg_stereo`=0 (mono), the right slot is transmitted as zeros and `rx_right` reads 0.
- R7: `tx_ready` is 1 while the single transmit holding register is empty. The held word is loaded for transmission at the frame start, which empties the holding register again.
- R8: If no word is held at a frame start, the whole frame is transmitted as zeros and `err_underrun` is set. It stays set until reset.
- R9: `rx_valid` rises after the last bit of a frame. It holds the words steady until `rx_ready` is seen high.
- R10: If a frame completes while `rx_valid`=1 and `rx_ready`=0, `err_overrun` is set (sticky) and the newest words replace the old ones.
- R11: A sync sampled before the last bit of a frame sets `err_sync` (sticky) and restarts the frame at bit 0 on the next falling edge. The aborted frame yields no receive word.
- R12: Audio shorter than 16 bits, left-justified with zero fill, crosses the port unchanged. For example, 8-bit sample 0xA5 is carried as element 0xA500.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be at least 12x the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | Bit clock from the codec |
| fsync_in | input | 1 | Active-high frame sync from the codec |
| sdata_in | input | 1 | Serial data from the codec |
| sdata_out | output | 1 | Serial data to the codec |
| cfg_short | input | 1 | 1 = 32-bit gated-clock frame, 0 = 64-bit frame; sampled at frame start |
| cfg_stereo | input | 1 | 1 = stereo, 0 = mono; sampled at frame start |
| tx_valid | input | 1 | Host offers a transmit word pair |
| tx_ready | output | 1 | Transmit holding register is empty |
| tx_left | input | 16 | Left element to transmit |
| tx_right | input | 16 | Right element to transmit |
| rx_valid | output | 1 | Received words are available |
| rx_ready | input | 1 | Host takes the received words |
| rx_left | output | 16 | Received left element |
| rx_right | output | 16 | Received right element |
| rx_status | output | 32 | Received status slot (long frame only) |
| err_sync | output | 1 | Sticky: sync arrived mid-frame |
| err_underrun | output | 1 | Sticky: frame started with no transmit word |
| err_overrun | output | 1 | Sticky: receive word overwritten unread |

## Verification
Every serial input passes two synchronizer stages and an edge register. As a result, `sdata_out` settles three system cycles after the bit clock rises. `rx_valid` and the error flags change three to four cycles after the falling edge that carries the deciding bit.

The bench runs each bit period as 8 system cycles high and 8 low. It reads `sdata_out` and the flags at the last negative system edge before it lowers the bit clock, which is well after they have settled. Receive words are compared by a monitor at the negative system edge on which valid and ready are both high. Expected words are queued before the driver starts the frame that produces them, so each completion finds its entry in the queue.

// File: rtl/afp_pkg.sv
package afp_pkg;
    typedef enum logic [0:0] {
        FP_IDLE  = 1'b0,
        FP_SHIFT = 1'b1
    } fp_state_e;
endpackage

// File: rtl/afp_edge_sync.sv
module afp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_raw,
    input  logic fsync_raw,
    input  logic sdin_raw,
    output logic fsync_s,
    output logic sdin_s,
    output logic bclk_rise,
    output logic bclk_fall
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] raw_vec;
    logic [NSIG-1:0] synced;
    logic            bclk_d;

    assign raw_vec = {bclk_raw, fsync_raw, sdin_raw};

    for (genvar g = 0; g < NSIG; g++) begin : g_sync
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], raw_vec[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bclk_d <= 1'b0;
        else        bclk_d <= synced[2];
    end

    assign bclk_rise = synced[2] & ~bclk_d;
    assign bclk_fall = ~synced[2] & bclk_d;
    assign fsync_s   = synced[1];
    assign sdin_s    = synced[0];
endmodule

// File: rtl/afp_frame_ctrl.sv
module afp_frame_ctrl
    import afp_pkg::*;
#(
    parameter int LONG_BITS  = 64,
    parameter int SHORT_BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_fall,
    input  logic fsync_s,
    input  logic cfg_short,
    input  logic cfg_stereo,
    output logic frame_start,
    output logic bit_take,
    output logic frame_done,
    output logic sync_err,
    output logic short_q,
    output logic stereo_q
);
    localparam int CNT_W = $clog2(LONG_BITS);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_BITS - 1);

    fp_state_e        state_q, state_d;
    logic [CNT_W-1:0] idx_q, idx_d;
    logic             last_bit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= FP_IDLE;
            idx_q    <= '0;
            short_q  <= 1'b0;
            stereo_q <= 1'b1;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (frame_start) begin
                short_q  <= cfg_short;
                stereo_q <= cfg_stereo;
            end
        end
    end

    assign last_bit = (idx_q == (short_q ? LAST_SHORT : LAST_LONG));

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        idx_d       = idx_q;
        frame_start = 1'b0;
        bit_take    = 1'b0;
        frame_done  = 1'b0;
        sync_err    = 1'b0;
        unique case (state_q)
            FP_IDLE: begin
                if (bclk_fall && fsync_s) begin
                    frame_start = 1'b1;
                    state_d     = FP_SHIFT;
                    idx_d       = '0;
                end
            end
            FP_SHIFT: begin
                if (bclk_fall) begin
                    bit_take   = 1'b1;
                    frame_done = last_bit;
                    if (fsync_s) begin
                        frame_start = 1'b1;
                        sync_err    = !last_bit;
                        idx_d       = '0;
                    end else if (last_bit) begin
                        state_d = FP_IDLE;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            default: state_d = FP_IDLE;
        endcase
    end
endmodule

// File: rtl/afp_tx_path.sv
module afp_tx_path #(
    parameter int ELEM_W    = 16,
    parameter int LONG_BITS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic [ELEM_W-1:0] tx_left,
    input  logic [ELEM_W-1:0] tx_right,
    output logic              tx_ready,
    input  logic              frame_start,
    input  logic              cfg_stereo,
    input  logic              bclk_rise,
    output logic              sdata_out,
    output logic              underrun
);
    localparam int PAD_W = LONG_BITS - 2 * ELEM_W;

    logic                 hold_full;
    logic [ELEM_W-1:0]    hold_l, hold_r;
    logic [LONG_BITS-1:0] sh_q;
    logic                 accept;

    assign tx_ready = !hold_full;
    assign accept   = tx_valid && !hold_full;
    assign underrun = frame_start && !hold_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_l    <= '0;
            hold_r    <= '0;
        end else begin
            if (frame_start && hold_full) hold_full <= 1'b0;
            if (accept) begin
                hold_full <= 1'b1;
                hold_l    <= tx_left;
                hold_r    <= tx_right;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q      <= '0;
            sdata_out <= 1'b0;
        end else if (frame_start) begin
            if (hold_full)
                sh_q <= {hold_l, (cfg_stereo ? hold_r : {ELEM_W{1'b0}}), {PAD_W{1'b0}}};
            else
                sh_q <= '0;
        end else if (bclk_rise) begin
            sdata_out <= sh_q[LONG_BITS-1];
            sh_q      <= {sh_q[LONG_BITS-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/afp_rx_path.sv
module afp_rx_path #(
    parameter int ELEM_W     = 16,
    parameter int LONG_BITS  = 64,
    parameter int SHORT_BITS = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bit_take,
    input  logic                   sdin_s,
    input  logic                   frame_done,
    input  logic                   short_q,
    input  logic                   stereo_q,
    input  logic                   rx_ready,
    output logic                   rx_valid,
    output logic [ELEM_W-1:0]      rx_left,
    output logic [ELEM_W-1:0]      rx_right,
    output logic [2*ELEM_W-1:0]    rx_status,
    output logic                   overrun
);
    localparam int STAT_W = LONG_BITS - 2 * ELEM_W;

    logic [LONG_BITS-1:0] sh_q, sh_nxt;
    logic [ELEM_W-1:0]    cap_l, cap_r;
    logic [STAT_W-1:0]    cap_s;

    assign sh_nxt  = {sh_q[LONG_BITS-2:0], sdin_s};
    assign overrun = frame_done && rx_valid && !rx_ready;

    always_comb begin
        if (short_q) begin
            cap_l = sh_nxt[SHORT_BITS-1 -: ELEM_W];
            cap_r = sh_nxt[ELEM_W-1:0];
            cap_s = '0;
        end else begin
            cap_l = sh_nxt[LONG_BITS-1 -: ELEM_W];
            cap_r = sh_nxt[LONG_BITS-ELEM_W-1 -: ELEM_W];
            cap_s = sh_nxt[STAT_W-1:0];
        end
        if (!stereo_q) cap_r = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q      <= '0;
            rx_valid  <= 1'b0;
            rx_left   <= '0;
            rx_right  <= '0;
            rx_status <= '0;
        end else begin
            if (bit_take) sh_q <= sh_nxt;
            if (frame_done) begin
                rx_valid  <= 1'b1;
                rx_left   <= cap_l;
                rx_right  <= cap_r;
                rx_status <= cap_s;
            end else if (rx_ready) begin
                rx_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/aud_frame_port.sv
module aud_frame_port #(
    parameter int ELEM_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_in,
    input  logic                fsync_in,
    input  logic                sdata_in,
    output logic                sdata_out,
    input  logic                cfg_short,
    input  logic                cfg_stereo,
    input  logic                tx_valid,
    output logic                tx_ready,
    input  logic [ELEM_W-1:0]   tx_left,
    input  logic [ELEM_W-1:0]   tx_right,
    output logic                rx_valid,
    input  logic                rx_ready,
    output logic [ELEM_W-1:0]   rx_left,
    output logic [ELEM_W-1:0]   rx_right,
    output logic [2*ELEM_W-1:0] rx_status,
    output logic                err_sync,
    output logic                err_underrun,
    output logic                err_overrun
);
    localparam int LONG_BITS  = 4 * ELEM_W;
    localparam int SHORT_BITS = 2 * ELEM_W;

    logic fsync_s, sdin_s, bclk_rise, bclk_fall;
    logic frame_start, bit_take, frame_done, sync_err;
    logic short_q, stereo_q;
    logic underrun, overrun;

    afp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .bclk_raw(bclk_in), .fsync_raw(fsync_in), .sdin_raw(sdata_in),
        .fsync_s(fsync_s), .sdin_s(sdin_s),
        .bclk_rise(bclk_rise), .bclk_fall(bclk_fall)
    );

    afp_frame_ctrl #(.LONG_BITS(LONG_BITS), .SHORT_BITS(SHORT_BITS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .bclk_fall(bclk_fall), .fsync_s(fsync_s),
        .cfg_short(cfg_short), .cfg_stereo(cfg_stereo),
        .frame_start(frame_start), .bit_take(bit_take),
        .frame_done(frame_done), .sync_err(sync_err),
        .short_q(short_q), .stereo_q(stereo_q)
    );

    afp_tx_path #(.ELEM_W(ELEM_W), .LONG_BITS(LONG_BITS)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_left(tx_left), .tx_right(tx_right),
        .tx_ready(tx_ready), .frame_start(frame_start),
        .cfg_stereo(cfg_stereo), .bclk_rise(bclk_rise),
        .sdata_out(sdata_out), .underrun(underrun)
    );

    afp_rx_path #(.ELEM_W(ELEM_W), .LONG_BITS(LONG_BITS), .SHORT_BITS(SHORT_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .bit_take(bit_take), .sdin_s(sdin_s), .frame_done(frame_done),
        .short_q(short_q), .stereo_q(stereo_q), .rx_ready(rx_ready),
        .rx_valid(rx_valid), .rx_left(rx_left), .rx_right(rx_right),
        .rx_status(rx_status), .overrun(overrun)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_sync     <= 1'b0;
            err_underrun <= 1'b0;
            err_overrun  <= 1'b0;
        end else begin
            if (sync_err) err_sync     <= 1'b1;
            if (underrun) err_underrun <= 1'b1;
            if (overrun)  err_overrun  <= 1'b1;
        end
    end
endmodule

// File: rtl/aud_frame_port_chk.sv
module aud_frame_port_chk #(
    parameter int ELEM_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sdata_out,
    input logic                bclk_rise,
    input logic                frame_done,
    input logic                short_q,
    input logic                stereo_q,
    input logic                tx_valid,
    input logic                tx_ready,
    input logic                rx_valid,
    input logic                rx_ready,
    input logic [ELEM_W-1:0]   rx_left,
    input logic [ELEM_W-1:0]   rx_right,
    input logic [2*ELEM_W-1:0] rx_status,
    input logic                err_sync,
    input logic                err_underrun,
    input logic                err_overrun
);
    p_sdout_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata_out) |-> $past(bclk_rise));

    p_tx_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    p_rx_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> rx_valid);

    p_rx_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready && !frame_done) |=> $stable({rx_left, rx_right, rx_status}));

    p_short_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_valid) && $past(short_q)) |-> (rx_status == '0));

    p_mono_right_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_valid) && !$past(stereo_q)) |-> (rx_right == '0));

    p_under_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_underrun |=> err_underrun);

    p_over_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun |=> err_overrun);

    p_over_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun) |-> $past(rx_valid && !rx_ready));

    p_sync_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_sync |=> err_sync);
endmodule

bind aud_frame_port aud_frame_port_chk #(.ELEM_W(ELEM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sdata_out(sdata_out),
    .bclk_rise(bclk_rise), .frame_done(frame_done),
    .short_q(short_q), .stereo_q(stereo_q),
    .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_left(rx_left), .rx_right(rx_right), .rx_status(rx_status),
    .err_sync(err_sync), .err_underrun(err_underrun), .err_overrun(err_overrun)
);

// File: tb/tb_aud_frame_port.sv
`timescale 1ns/1ps
module tb_aud_frame_port;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_in = 1'b0, fsync_in = 1'b0, sdata_in = 1'b0;
    logic        sdata_out;
    logic        cfg_short = 1'b0, cfg_stereo = 1'b1;
    logic        tx_valid = 1'b0, tx_ready;
    logic [15:0] tx_left = '0, tx_right = '0;
    logic        rx_valid, rx_ready = 1'b1;
    logic [15:0] rx_left, rx_right;
    logic [31:0] rx_status;
    logic        err_sync, err_underrun, err_overrun;

    int          n_cmp = 0, n_bad = 0;
    logic [63:0] exp_q[$];
    logic [63:0] mon_exp;
    bit          mon_en = 1'b1;

    always #2.5 clk = ~clk;

    aud_frame_port dut (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .fsync_in(fsync_in),
        .sdata_in(sdata_in), .sdata_out(sdata_out),
        .cfg_short(cfg_short), .cfg_stereo(cfg_stereo),
        .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_left(tx_left), .tx_right(tx_right),
        .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_left(rx_left), .rx_right(rx_right), .rx_status(rx_status),
        .err_sync(err_sync), .err_underrun(err_underrun), .err_overrun(err_overrun)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor for receive words
    always @(negedge clk) begin
        if (mon_en && rx_valid && rx_ready) begin
            if (exp_q.size() == 0) begin
                chk("R11 unexpected rx word", {rx_left, rx_right, rx_status}, 64'h0);
            end else begin
                mon_exp = exp_q.pop_front();
                chk("R3/R9 rx word", {rx_left, rx_right, rx_status}, mon_exp);
            end
        end
    end

    task automatic expect_rx(input logic [15:0] l, input logic [15:0] r, input logic [31:0] s);
        exp_q.push_back({l, r, s});
    endtask

    task automatic bit_cycle(input logic fs, input logic din, output logic dout);
        @(negedge clk);
        bclk_in = 1'b1; fsync_in = fs; sdata_in = din;
        repeat (HALF - 1) @(negedge clk);
        dout = sdata_out;
        @(negedge clk);
        bclk_in = 1'b0;
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic sync_bit();
        logic d;
        bit_cycle(1'b1, 1'b0, d);
    endtask

    task automatic drive_frame(input bit shrt, input logic [15:0] l, input logic [15:0] r,
                               input logic [31:0] st, input bit nsync, output logic [63:0] got);
        logic [63:0] fw;
        logic        d;
        int          n;
        fw  = shrt ? {l, r, 32'h0} : {l, r, st};
        n   = shrt ? 32 : 64;
        got = '0;
        for (int i = 0; i < n; i++) begin
            bit_cycle((i == n - 1) && nsync, fw[63 - i], d);
            got[63 - i] = d;
        end
        fsync_in = 1'b0;
        if (shrt) repeat (256) @(negedge clk);
    endtask

    task automatic push_tx(input logic [15:0] l, input logic [15:0] r);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_valid = 1'b1; tx_left = l; tx_right = r;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bclk_in = 1'b0; fsync_in = 1'b0; sdata_in = 1'b0; tx_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog R1-path run hung: act=timeout exp=finished");
        summary();
        $finish;
    end

    initial begin
        logic [63:0] got;
        do_reset();
        // R1 reset state
        chk("R1 reset outputs", {60'h0, sdata_out, rx_valid, tx_ready, 1'b0},
            {60'h0, 1'b0, 1'b0, 1'b1, 1'b0});
        chk("R1 reset flags", {61'h0, err_sync, err_underrun, err_overrun}, 64'h0);

        // long stereo frames back to back
        cfg_short = 1'b0; cfg_stereo = 1'b1;
        push_tx(16'h0F0F, 16'hF00D);
        chk("R7 ready low while held", {63'h0, tx_ready}, 64'h0);
        sync_bit();
        chk("R7 ready after frame start", {63'h0, tx_ready}, 64'h1);
        push_tx(16'h1357, 16'h2468);
        expect_rx(16'hA5C3, 16'h1234, 32'hDEADBEEF);
        drive_frame(1'b0, 16'hA5C3, 16'h1234, 32'hDEADBEEF, 1'b1, got);
        chk("R2 R3 R4 tx frame 1", got, {16'h0F0F, 16'hF00D, 32'h0});
        push_tx(16'hA500, 16'hC000);
        expect_rx(16'h8001, 16'h7FFE, 32'h00000001);
        drive_frame(1'b0, 16'h8001, 16'h7FFE, 32'h00000001, 1'b1, got);
        chk("R4 tx frame 2", got, {16'h1357, 16'h2468, 32'h0});
        expect_rx(16'h5A00, 16'h0030, 32'h80000000);
        drive_frame(1'b0, 16'h5A00, 16'h0030, 32'h80000000, 1'b0, got);
        chk("R12 left-justified tx", got, {16'hA500, 16'hC000, 32'h0});
        repeat (20) @(negedge clk);
        chk("R9 all long words delivered", 64'(exp_q.size()), 64'h0);
        chk("R4 no flag on bit-63 sync", {61'h0, err_sync, err_underrun, err_overrun}, 64'h0);

        // mono
        cfg_stereo = 1'b0;
        push_tx(16'hBEEF, 16'h1111);
        sync_bit();
        expect_rx(16'hC0DE, 16'h0000, 32'h00FF00FF);
        drive_frame(1'b0, 16'hC0DE, 16'h9999, 32'h00FF00FF, 1'b0, got);
        chk("R6 mono tx right slot zero", got, {16'hBEEF, 16'h0000, 32'h0});

        // short gated-clock frames
        cfg_short = 1'b1; cfg_stereo = 1'b1;
        push_tx(16'hABCD, 16'hEF01);
        sync_bit();
        expect_rx(16'h3C3C, 16'hC3C3, 32'h0);
        drive_frame(1'b1, 16'h3C3C, 16'hC3C3, 32'h0, 1'b0, got);
        chk("R5 short tx frame 1", got, {16'hABCD, 16'hEF01, 32'h0});
        push_tx(16'h0001, 16'h8000);
        sync_bit();
        expect_rx(16'hFFFF, 16'h0000, 32'h0);
        drive_frame(1'b1, 16'hFFFF, 16'h0000, 32'h0, 1'b0, got);
        chk("R5 short tx frame 2", got, {16'h0001, 16'h8000, 32'h0});
        repeat (20) @(negedge clk);
        chk("R5 stopped clock raises no flag", {61'h0, err_sync, err_underrun, err_overrun}, 64'h0);

        // underrun
        do_reset();
        cfg_short = 1'b0; cfg_stereo = 1'b1;
        sync_bit();
        expect_rx(16'h1234, 16'h5678, 32'h0);
        drive_frame(1'b0, 16'h1234, 16'h5678, 32'h0, 1'b0, got);
        chk("R8 underrun sends zeros", got, 64'h0);
        chk("R8 underrun flag", {63'h0, err_underrun}, 64'h1);

        // overrun
        do_reset();
        mon_en = 1'b0; rx_ready = 1'b0;
        push_tx(16'h0001, 16'h0002);
        sync_bit();
        push_tx(16'h0003, 16'h0004);
        drive_frame(1'b0, 16'hAAAA, 16'hBBBB, 32'hCCCCCCCC, 1'b1, got);
        chk("R9 valid held without ready", {47'h0, rx_valid, rx_left}, {47'h0, 1'b1, 16'hAAAA});
        drive_frame(1'b0, 16'h1111, 16'h2222, 32'h33333333, 1'b0, got);
        chk("R10 overrun flag", {63'h0, err_overrun}, 64'h1);
        chk("R10 newest word kept", {rx_left, rx_right, rx_status}, {16'h1111, 16'h2222, 32'h33333333});
        rx_ready = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 valid drops after ready", {63'h0, rx_valid}, 64'h0);
        mon_en = 1'b1;

        // early sync
        do_reset();
        push_tx(16'h7777, 16'h8888);
        sync_bit();
        push_tx(16'h9999, 16'hAAAA);
        for (int i = 0; i < 20; i++) begin
            logic d;
            bit_cycle(i == 19, 1'b1, d);
        end
        fsync_in = 1'b0;
        chk("R11 sync error flag", {63'h0, err_sync}, 64'h1);
        expect_rx(16'h4321, 16'h8765, 32'h0F0F0F0F);
        drive_frame(1'b0, 16'h4321, 16'h8765, 32'h0F0F0F0F, 1'b0, got);
        chk("R11 tx restarts at bit 0", got, {16'h9999, 16'hAAAA, 32'h0});
        repeat (20) @(negedge clk);
        chk("R11 aborted frame gives no word", 64'(exp_q.size()), 64'h0);

        summary();
        $finish;
    end
endmodule